// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character into a serial frame on a single output line. Each frame is a low start bit, then 5 to 9 data bits least significant first, then an optional even or odd parity bit, then one or two high stop bits. The format is picked at run time from configuration inputs. An internal divider sets the bit rate from the system clock. The divisor, the format and the data word are all captured when a load strobe is accepted, so they cannot change while that frame is on the line.

In asynchronous mode each bit lasts one divider period. In synchronous mode the block also drives a transfer clock. Each bit then lasts two divider periods, and the transfer clock makes one sample edge in the middle of the bit and one change edge at its end. A polarity input chooses which transfer-clock edge is the change edge. A ready flag tells the host when a load will be taken. A one-cycle done pulse marks the last clock of every frame. A load made in that last clock starts the next frame with no idle bit in between.

Top module: `serial_frame_tx`

## Requirements
- R1: After a load is accepted, `txd` goes low on the next clock and stays low for one bit period. A bit period is `baud_div`+1 clocks in asynchronous mode and 2×(`baud_div`+1) clocks in synchronous mode.
- R2: Data bits follow the start bit least significant first, one bit period each. `len_sel` 0,1,2,3,4 selects 5,6,7,8,9 data bits; codes 5 to 7 select 9.
- R3: `par_mode` 2'b01 adds an even-parity bit and 2'b10 adds an odd-parity bit, placed right after the last data bit. With even parity the ones in data plus parity number an even count; with odd parity, an odd count. Only the selected data bits are counted. Codes 2'b00 and 2'b11 add no parity bit.
- R4: The frame ends with one high stop bit when `two_stop`=0 and two high stop bits when `two_stop`=1.
- R5: While no frame is in progress, `txd` is high. A load accepted in the final clock of a frame makes the next start bit begin on the very next clock.
- R6: With `sync_mode`=1 and `clk_pol`=0, `xck` is low at the start of each bit, rises after `baud_div`+1 clocks and falls when the line moves to the next bit. With `clk_pol`=1 the levels are inverted.
- R7: `xck` equals `clk_pol` while idle, and stays at the captured polarity level for the whole of an asynchronous frame.
- R8: Data, format, mode, polarity and divisor are captured at acceptance. Changing these inputs during a frame has no effect on that frame.
- R9: `ready` is high while idle and during the final clock of a frame, and low otherwise. A load while `ready` is low is ignored.
- R10: `frame_done` is a one-clock pulse in the final clock of each frame's last stop bit.
- R11: During and right after reset, `txd`=1, `ready`=1, `frame_done`=0 and `xck`=`clk_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Divider value; one divider period is baud_div+1 clocks |
| tx_data | input | 9 | Character to send; upper bits unused for short lengths |
| load | input | 1 | Request to start a frame with the current inputs |
| len_sel | input | 3 | Data length code |
| par_mode | input | 2 | Parity code: none, even, odd |
| two_stop | input | 1 | Selects two stop bits |
| sync_mode | input | 1 | Enables transfer-clock output timing |
| clk_pol | input | 1 | Transfer-clock idle level; the change edge goes back to this level |
| txd | output | 1 | Serial data line |
| xck | output | 1 | Transfer clock |
| ready | output | 1 | A load is accepted this clock |
| frame_done | output | 1 | Final clock of a frame |

## Verification
The bench runs all thirty formats, both transfer-clock polarities and a zero divisor, and compares every clock against a queue-based model. Back-to-back loads catch a design that adds an idle bit, or drops the second frame, at the frame boundary. Loads made mid-frame, and format inputs changed mid-frame, catch a design that restarts, corrupts the bit stream or reads the configuration live. The parity cases with nine and with five data bits catch a parity count that includes unused data bits or has the wrong sense.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_t;

  function automatic logic [CNT_W-1:0] data_len(input logic [2:0] sel);
    case (sel)
      3'd0:    data_len = CNT_W'(5);
      3'd1:    data_len = CNT_W'(6);
      3'd2:    data_len = CNT_W'(7);
      3'd3:    data_len = CNT_W'(8);
      default: data_len = CNT_W'(9);
    endcase
  endfunction

  function automatic logic par_on(input par_mode_t pm);
    par_on = (pm == PAR_EVEN) || (pm == PAR_ODD);
  endfunction

  function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                     input logic [CNT_W-1:0] len,
                                     input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < len) acc = acc ^ d[i];
    end
    parity_of = acc;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic [2:0] sel,
                                                 input par_mode_t pm,
                                                 input logic two);
    frame_len = CNT_W'(2) + data_len(sel) + CNT_W'(par_on(pm)) + CNT_W'(two);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                     input logic [2:0] sel,
                                                     input par_mode_t pm);
    logic [FRAME_W-1:0] v;
    logic [CNT_W-1:0]   len;
    len  = data_len(sel);
    v    = '1;
    v[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < len) v[1+i] = d[i];
    end
    if (par_on(pm)) v[32'(len) + 1] = parity_of(d, len, pm == PAR_ODD);
    build_frame = v;
  endfunction
endpackage

// File: rtl/sft_baud_gen.sv
module sft_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;

  assign tick = run && (cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else if (restart) begin
      cnt   <= '0;
      div_q <= div;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  // R1
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div_q));
endmodule

// File: rtl/sft_frame_builder.sv
module sft_frame_builder
  import sft_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  logic [2:0]         len_sel,
  input  par_mode_t          par,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  always_comb begin
    frame = build_frame(data, len_sel, par);
    nbits = frame_len(len_sel, par, two_stop);
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
  import sft_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  input  logic               sync_in,
  input  logic               pol_in,
  input  logic               tick,
  output logic               txd,
  output logic               xck_r,
  output logic               busy,
  output logic               adv,
  output logic               frame_end
);
  logic [FRAME_W-1:0] shift;
  logic [CNT_W-1:0]   rem;
  logic               half;
  logic               sync_q;
  logic               pol_q;

  assign adv       = busy && tick && (!sync_q || half);
  assign frame_end = adv && (rem == CNT_W'(1));
  assign txd       = busy ? shift[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift  <= '1;
      rem    <= '0;
      busy   <= 1'b0;
      half   <= 1'b0;
      xck_r  <= 1'b0;
      sync_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (start) begin
      shift  <= frame_in;
      rem    <= nbits_in;
      busy   <= 1'b1;
      half   <= 1'b0;
      xck_r  <= pol_in;
      sync_q <= sync_in;
      pol_q  <= pol_in;
    end else if (busy) begin
      if (tick && sync_q) begin
        half  <= ~half;
        xck_r <= half ? pol_q : ~pol_q;
      end
      if (adv) begin
        shift <= {1'b1, shift[FRAME_W-1:1]};
        rem   <= rem - 1'b1;
      end
      if (frame_end) busy <= 1'b0;
    end
  end

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && (txd == 1'b0)));

  // R6
  change_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sync_q) |=> (xck_r == pol_q));

  // R7
  async_xck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sync_q && !start) |=> $stable(xck_r));

  // R9
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv && !start) |=> ($stable(rem) && $stable(shift)));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [8:0]       tx_data,
  input  logic             load,
  input  logic [2:0]       len_sel,
  input  logic [1:0]       par_mode,
  input  logic             two_stop,
  input  logic             sync_mode,
  input  logic             clk_pol,
  output logic             txd,
  output logic             xck,
  output logic             ready,
  output logic             frame_done
);
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               tick;
  logic               busy;
  logic               adv;
  logic               frame_end;
  logic               xck_r;
  logic               start;

  assign ready      = !busy || frame_end;
  assign start      = load && ready;
  assign frame_done = frame_end;
  assign xck        = busy ? xck_r : clk_pol;

  sft_frame_builder u_build (
    .data     (tx_data),
    .len_sel  (len_sel),
    .par      (par_mode_t'(par_mode)),
    .two_stop (two_stop),
    .frame    (frame),
    .nbits    (nbits)
  );

  sft_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .run     (busy),
    .div     (baud_div),
    .tick    (tick)
  );

  sft_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame_in  (frame),
    .nbits_in  (nbits),
    .sync_in   (sync_mode),
    .pol_in    (clk_pol),
    .tick      (tick),
    .txd       (txd),
    .xck_r     (xck_r),
    .busy      (busy),
    .adv       (adv),
    .frame_end (frame_end)
  );

  // R5
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !load) |=> (ready && txd));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic [8:0]  tx_data = '0;
  logic        load = 1'b0;
  logic [2:0]  len_sel = '0;
  logic [1:0]  par_mode = '0;
  logic        two_stop = 1'b0;
  logic        sync_mode = 1'b0;
  logic        clk_pol = 1'b0;
  logic        txd, xck, ready, frame_done;

  always #5 clk = ~clk;

  serial_frame_tx #(.DIV_W(16)) i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_data(tx_data),
    .load(load), .len_sel(len_sel), .par_mode(par_mode), .two_stop(two_stop),
    .sync_mode(sync_mode), .clk_pol(clk_pol), .txd(txd), .xck(xck),
    .ready(ready), .frame_done(frame_done)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit comparing = 0;
  string section = "R11";

  // reference model
  bit    q[$];
  string tq[$];
  bit    m_busy = 0;
  int    m_cnt = 0;
  int    m_half = 1;
  int    m_per = 1;
  bit    m_sync = 0;
  bit    m_pol = 0;

  function automatic bit m_end();
    return m_busy && (q.size() == 1) && (m_cnt == m_per - 1);
  endfunction

  task automatic fill_queue();
    int  n;
    bit  p;
    bit  use_par;
    n = (len_sel > 3'd4) ? 9 : 5 + int'(len_sel);
    q.delete();
    tq.delete();
    q.push_back(1'b0); tq.push_back("R1");
    for (int i = 0; i < n; i++) begin
      q.push_back(tx_data[i]); tq.push_back("R2");
    end
    use_par = (par_mode == 2'b01) || (par_mode == 2'b10);
    if (use_par) begin
      p = ($countones(tx_data & ((9'h1 << n) - 9'h1)) % 2) == 1;
      if (par_mode == 2'b10) p = ~p;
      q.push_back(p); tq.push_back("R3");
    end
    q.push_back(1'b1); tq.push_back("R4");
    if (two_stop) begin
      q.push_back(1'b1); tq.push_back("R4");
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if ((!m_busy || m_end()) && load) begin
        fill_queue();
        m_busy = 1;
        m_cnt  = 0;
        m_sync = sync_mode;
        m_pol  = clk_pol;
        m_half = int'(baud_div) + 1;
        m_per  = sync_mode ? 2 * m_half : m_half;
      end else if (m_busy) begin
        if (m_cnt == m_per - 1) begin
          void'(q.pop_front());
          void'(tq.pop_front());
          m_cnt = 0;
          if (q.size() == 0) m_busy = 0;
        end else begin
          m_cnt++;
        end
      end
    end
  end

  task automatic check_bit(input string tag, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", tag, section, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (comparing) begin
      bit e_txd, e_xck, e_end;
      string ttag;
      e_end = m_end();
      e_txd = m_busy ? q[0] : 1'b1;
      ttag  = m_busy ? tq[0] : "R5";
      if (m_busy && m_sync) e_xck = (m_cnt >= m_half) ? ~m_pol : m_pol;
      else if (m_busy)      e_xck = m_pol;
      else                  e_xck = clk_pol;
      check_bit({ttag, " txd"}, txd, e_txd);
      check_bit(m_busy && m_sync ? "R6 xck" : "R7 xck", xck, e_xck);
      check_bit("R9 ready", ready, !m_busy || e_end);
      check_bit("R10 frame_done", frame_done, e_end);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int len, input int par,
                      input bit two, input bit sy, input bit pol, input int div);
    @(negedge clk);
    tx_data = d; len_sel = 3'(len); par_mode = 2'(par); two_stop = two;
    sync_mode = sy; clk_pol = pol; baud_div = 16'(div);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    wait_idle();
  endtask

  initial begin
    clk_pol = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state with polarity high
    check_bit("R11 txd", txd, 1'b1);
    check_bit("R11 ready", ready, 1'b1);
    check_bit("R11 frame_done", frame_done, 1'b0);
    check_bit("R11 xck", xck, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R11 xck after release", xck, 1'b1);
    comparing = 1;

    // all thirty formats, asynchronous
    section = "R2 R3 R4";
    for (int l = 0; l < 5; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++)
          send(9'((l * 97 + p * 41 + s * 13 + 5) & 9'h1FF), l, p, s[0], 1'b0, 1'b0, 1);

    // parity counts only the selected bits; reserved code adds none
    section = "R3";
    send(9'h1E0, 0, 1, 1'b0, 1'b0, 1'b0, 1);
    send(9'h1E0, 0, 2, 1'b0, 1'b0, 1'b0, 1);
    send(9'h1FF, 4, 1, 1'b0, 1'b0, 1'b0, 0);
    send(9'h1FF, 4, 2, 1'b1, 1'b0, 1'b0, 0);
    send(9'h0A5, 3, 3, 1'b0, 1'b0, 1'b0, 1);

    // synchronous, both polarities
    section = "R6";
    send(9'h0C3, 3, 1, 1'b0, 1'b1, 1'b0, 2);
    send(9'h13C, 4, 2, 1'b1, 1'b1, 1'b1, 2);
    send(9'h015, 0, 0, 1'b0, 1'b1, 1'b0, 0);

    // asynchronous frame with high idle polarity: xck must stay put
    section = "R7";
    send(9'h055, 3, 0, 1'b0, 1'b0, 1'b1, 2);

    // back-to-back loads
    section = "R5";
    @(negedge clk);
    tx_data = 9'h0F1; len_sel = 3'd3; par_mode = 2'b01; two_stop = 1'b0;
    sync_mode = 1'b0; clk_pol = 1'b0; baud_div = 16'd1;
    load = 1'b1;
    repeat (60) @(negedge clk);
    tx_data = 9'h0A3;
    repeat (40) @(negedge clk);
    load = 1'b0;
    wait_idle();

    // load while busy ignored
    section = "R9";
    @(negedge clk);
    tx_data = 9'h03C; len_sel = 3'd3; par_mode = 2'b00; baud_div = 16'd3;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (5) @(negedge clk);
    tx_data = 9'h1FF;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    #1;
    check_bit("R9 ready low after ignored load", ready, 1'b0);
    wait_idle();

    // configuration changed mid-frame
    section = "R8";
    @(negedge clk);
    tx_data = 9'h0B2; len_sel = 3'd2; par_mode = 2'b10; two_stop = 1'b1;
    sync_mode = 1'b1; clk_pol = 1'b0; baud_div = 16'd1;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (6) @(negedge clk);
    tx_data = 9'h14D; len_sel = 3'd4; par_mode = 2'b00; two_stop = 1'b0;
    sync_mode = 1'b0; clk_pol = 1'b1; baud_div = 16'd5;
    wait_idle();
    #1;
    check_bit("R7 idle xck follows polarity", xck, 1'b1);

    repeat (4) @(negedge clk);
    comparing = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule